// File: doc/BRIEF.md
# Radio Modem Command Controller

This controller sits between a 9-bit serial framer and the rest of a radio modem. Each packet from the host carries eight information bits and a control flag: a flag of 1 marks a command, a flag of 0 marks a data byte. The controller decodes commands, tracks whether the modem is idle, asleep, in transmit mode or waiting for a configuration value, and builds reply packets for the transmit framer.

A 32-entry byte register file holds the modem's variables. Configure commands write it and enquire commands read it. Data bytes that arrive in transmit mode go out on a radio-payload port. The start-transmission lead-in delay and the test-mode selection are kept as plain registers.

Replies wait in a two-slot queue. No new packet is accepted until every queued reply has been taken by the transmit framer.

Top module: `modem_cmd_ctrl`

## Requirements
- R1: A packet with `rx_ctrl`=1 is a command. Bits [7:5] are the opcode and bits [4:0] the parameter. The opcodes are 000 configure, 001 end transmission, 010 enquire, 011 test, 100 sleep, 101 start transmission, 110 undefined and 111 wake. Reply command bytes are ACK=0x00, RQD=0x01 and WAKAK=0x02, each sent with `tx_ctrl`=1.
- R2: Configure replies ACK and selects the register given by its parameter. The next data packet is written into that register and draws no reply.
- R3: Enquire replies RQD, followed by a data packet (`tx_ctrl`=0) that holds the selected register.
- R4: Sleep sends no reply and raises `asleep`. While asleep, any packet clears `asleep` and draws WAKAK, and the packet itself is not executed.
- R5: Wake replies WAKAK and changes nothing else. In particular, transmit mode is kept.
- R6: Start transmission replies ACK, sets `tx_mode` and loads its parameter into `lead_delay`. In transmit mode, each data packet is pulsed on `pay_valid`/`pay_byte` in the cycle after it is accepted, and is answered with ACK. End transmission replies ACK and clears `tx_mode`.
- R7: Test replies ACK and loads its parameter into `test_sel`. `test_active` is high exactly when `test_sel` is non-zero, so a parameter of 0 leaves test mode.
- R8: Opcode 110 draws no reply and changes no state. A pending configure remains pending.
- R9: A data packet that arrives while idle draws no reply, produces no payload and changes no register.
- R10: While replies are queued, `rx_ready` is low. A reply is held on `tx_valid`/`tx_byte`/`tx_ctrl` until `tx_ready` takes it, and queued replies go out in order.
- R11: After reset, all registers are zero, the controller is idle, `rx_ready`=1, `tx_valid`=0, and `asleep`, `tx_mode` and `test_active` are low.
- R12: Any defined command that arrives while a configure is pending cancels the configure, so the following data packet is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received packet present |
| rx_ctrl | input | 1 | 1 = command, 0 = data |
| rx_byte | input | 8 | Received information byte |
| rx_ready | output | 1 | Controller can accept a packet |
| tx_valid | output | 1 | Reply packet present |
| tx_ctrl | output | 1 | Reply control flag |
| tx_byte | output | 8 | Reply information byte |
| tx_ready | input | 1 | Transmit framer takes the reply |
| pay_valid | output | 1 | Radio payload byte strobe |
| pay_byte | output | 8 | Radio payload byte |
| asleep | output | 1 | Sleep state |
| tx_mode | output | 1 | Transmit mode |
| lead_delay | output | 5 | Lead-in delay from start transmission |
| test_sel | output | 5 | Selected test type |
| test_active | output | 1 | Test mode on |

## Verification
The first reply and any payload strobe become visible in the cycle right after the edge that accepts a packet. With `tx_ready` held high, each further queued reply follows one cycle later. The bench therefore drives a packet on a falling edge and samples on the following falling edges. It collects up to four cycles of replies, so it can tell a missing reply from an extra one.

Effects that should be absent (ignored data, an unexecuted command on wake-up, a cancelled configure) are made visible by a later enquire that reads the register back. In the stall scenario, `tx_ready` is held low and the held reply and the low `rx_ready` are checked on several consecutive falling edges.

// File: rtl/modem_cmd_ctrl.sv
module modem_cmd_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_ctrl,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic              tx_ctrl,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_ready,
  output logic              pay_valid,
  output logic [DATA_W-1:0] pay_byte,
  output logic              asleep,
  output logic              tx_mode,
  output logic [DATA_W-4:0] lead_delay,
  output logic [DATA_W-4:0] test_sel,
  output logic              test_active
);
  localparam int PAR_W = DATA_W - 3;
  localparam int NREG  = 1 << PAR_W;
  localparam logic [DATA_W-1:0] R_ACK = 'h00, R_RQD = 'h01, R_WAK = 'h02;
  localparam logic [2:0] OP_CFG = 3'd0, OP_END = 3'd1, OP_ENQ = 3'd2, OP_TST = 3'd3,
                         OP_SLP = 3'd4, OP_STT = 3'd5, OP_UND = 3'd6, OP_WAK = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_XMIT, S_SLEEP} mode_t;
  mode_t mode;

  logic [DATA_W-1:0] regs [NREG];
  logic [PAR_W-1:0]  cfg_addr;
  logic [1:0]        qcnt;
  logic [DATA_W-1:0] qb0, qb1;
  logic              qc0, qc1;

  wire              acc = rx_valid && rx_ready;
  wire [2:0]        op  = rx_byte[DATA_W-1 -: 3];
  wire [PAR_W-1:0]  par = rx_byte[PAR_W-1:0];

  assign rx_ready    = (qcnt == 2'd0);
  assign tx_valid    = (qcnt != 2'd0);
  assign tx_byte     = qb0;
  assign tx_ctrl     = qc0;
  assign asleep      = (mode == S_SLEEP);
  assign tx_mode     = (mode == S_XMIT);
  assign test_active = (test_sel != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= S_IDLE;
      cfg_addr   <= '0;
      qcnt       <= 2'd0;
      qb0        <= '0;
      qb1        <= '0;
      qc0        <= 1'b0;
      qc1        <= 1'b0;
      pay_valid  <= 1'b0;
      pay_byte   <= '0;
      lead_delay <= '0;
      test_sel   <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pay_valid <= 1'b0;
      if (tx_valid && tx_ready) begin
        qb0  <= qb1;
        qc0  <= qc1;
        qcnt <= qcnt - 2'd1;
      end
      if (acc) begin
        if (mode == S_SLEEP) begin
          qb0 <= R_WAK; qc0 <= 1'b1; qcnt <= 2'd1;
          mode <= S_IDLE;
        end else if (rx_ctrl) begin
          if (mode == S_CFG && op != OP_UND) mode <= S_IDLE;
          case (op)
            OP_CFG: begin
              qb0 <= R_ACK; qc0 <= 1'b1; qcnt <= 2'd1;
              cfg_addr <= par;
              mode <= S_CFG;
            end
            OP_END: begin
              qb0 <= R_ACK; qc0 <= 1'b1; qcnt <= 2'd1;
              mode <= S_IDLE;
            end
            OP_ENQ: begin
              qb0 <= R_RQD; qc0 <= 1'b1;
              qb1 <= regs[par]; qc1 <= 1'b0;
              qcnt <= 2'd2;
            end
            OP_TST: begin
              qb0 <= R_ACK; qc0 <= 1'b1; qcnt <= 2'd1;
              test_sel <= par;
            end
            OP_SLP: mode <= S_SLEEP;
            OP_STT: begin
              qb0 <= R_ACK; qc0 <= 1'b1; qcnt <= 2'd1;
              lead_delay <= par;
              mode <= S_XMIT;
            end
            OP_WAK: begin
              qb0 <= R_WAK; qc0 <= 1'b1; qcnt <= 2'd1;
            end
            default: ;
          endcase
        end else begin
          case (mode)
            S_CFG: begin
              regs[cfg_addr] <= rx_byte;
              mode <= S_IDLE;
            end
            S_XMIT: begin
              pay_valid <= 1'b1;
              pay_byte  <= rx_byte;
              qb0 <= R_ACK; qc0 <= 1'b1; qcnt <= 2'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_sleep_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == S_SLEEP) |=> (tx_valid && tx_ctrl && tx_byte == R_WAK && mode == S_IDLE));

  assert_enquire_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rx_ctrl && op == OP_ENQ && mode != S_SLEEP) |=> (tx_valid && tx_byte == R_RQD && qcnt == 2'd2 && !qc1));

  assert_payload_in_xmit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> ($past(mode) == S_XMIT && $past(acc) && !$past(rx_ctrl)));

  assert_undef_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rx_ctrl && op == OP_UND && mode != S_SLEEP) |=> (!tx_valid && $stable(mode)));

  assert_reply_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_ctrl) && !rx_ready));
endmodule

// File: tb/modem_cmd_ctrl_tb.sv
module modem_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ctrl = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_byte = '0;
  logic rx_ready, tx_valid, tx_ctrl, pay_valid, asleep, tx_mode, test_active;
  logic [7:0] tx_byte, pay_byte;
  logic [4:0] lead_delay, test_sel;

  int checks = 0, fails = 0, cycles = 0;
  int rn;
  logic [7:0] rb [4];
  logic rc [4];
  logic pv;
  logic [7:0] pb;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ctrl(tx_ctrl), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .pay_valid(pay_valid), .pay_byte(pay_byte), .asleep(asleep),
    .tx_mode(tx_mode), .lead_delay(lead_delay), .test_sel(test_sel), .test_active(test_active)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_ctrl = c; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rn = 0; pv = 1'b0; pb = '0;
    for (int k = 0; k < 4; k++) begin
      if (tx_valid) begin rb[rn] = tx_byte; rc[rn] = tx_ctrl; rn++; end
      if (pay_valid) begin pv = 1'b1; pb = pay_byte; end
      if (k < 3) @(negedge clk);
    end
  endtask

  task automatic expect_one(input logic [7:0] code, input string req);
    chk(rn == 1, req, rn, 1);
    if (rn >= 1) chk(rb[0] == code && rc[0] == 1'b1, req, {rc[0], rb[0]}, {1'b1, code});
  endtask

  task automatic expect_none(input string req);
    chk(rn == 0 && !pv, req, rn, 0);
  endtask

  task automatic expect_read(input logic [7:0] v, input string req);
    chk(rn == 2, req, rn, 2);
    if (rn == 2) begin
      chk(rb[0] == 8'h01 && rc[0], req, {rc[0], rb[0]}, 9'h101);
      chk(rb[1] == v && !rc[1], req, {rc[1], rb[1]}, {1'b0, v});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rx_ready && !tx_valid, "R11 handshake", {rx_ready, tx_valid}, 2'b10);
    chk(!asleep && !tx_mode && !test_active, "R11 state", {asleep, tx_mode, test_active}, 0);
    send(1'b1, 8'h4A);
    expect_read(8'h00, "R11 register zero");
  endtask

  task automatic t_config_enquire();
    send(1'b1, 8'h05);
    expect_one(8'h00, "R1/R2 configure ACK");
    send(1'b0, 8'hA5);
    expect_none("R2 data no reply");
    send(1'b1, 8'h45);
    expect_read(8'hA5, "R3 enquire written reg");
    send(1'b1, 8'h46);
    expect_read(8'h00, "R3 enquire other reg");
  endtask

  task automatic t_idle_data();
    send(1'b0, 8'h77);
    expect_none("R9 idle data");
    send(1'b1, 8'h40);
    expect_read(8'h00, "R9 no register change");
  endtask

  task automatic t_cancel();
    send(1'b1, 8'h07);
    expect_one(8'h00, "R12 configure ACK");
    send(1'b1, 8'hFF);
    expect_one(8'h02, "R5 wake WAKAK");
    send(1'b0, 8'h33);
    expect_none("R12 data after cancel");
    send(1'b1, 8'h47);
    expect_read(8'h00, "R12 reg untouched");
  endtask

  task automatic t_sleep();
    send(1'b1, 8'h80);
    expect_none("R4 sleep silent");
    chk(asleep, "R4 asleep", asleep, 1);
    send(1'b1, 8'h09);
    expect_one(8'h02, "R4 WAKAK on wake-up");
    chk(!asleep, "R4 awake", asleep, 0);
    send(1'b0, 8'h44);
    expect_none("R4 command not executed");
    send(1'b1, 8'h49);
    expect_read(8'h00, "R4 reg untouched");
    send(1'b1, 8'h80);
    send(1'b0, 8'h11);
    expect_one(8'h02, "R4 data wakes");
  endtask

  task automatic t_xmit();
    send(1'b1, 8'hAC);
    expect_one(8'h00, "R6 start ACK");
    chk(tx_mode && lead_delay == 5'd12, "R6 mode/lead", {tx_mode, lead_delay}, {1'b1, 5'd12});
    send(1'b0, 8'h5A);
    expect_one(8'h00, "R6 data ACK");
    chk(pv && pb == 8'h5A, "R6 payload", pb, 8'h5A);
    send(1'b1, 8'hFF);
    expect_one(8'h02, "R5 wake in xmit");
    chk(tx_mode, "R5 mode kept", tx_mode, 1);
    send(1'b1, 8'h20);
    expect_one(8'h00, "R6 end ACK");
    chk(!tx_mode, "R6 mode left", tx_mode, 0);
  endtask

  task automatic t_test();
    send(1'b1, 8'h63);
    expect_one(8'h00, "R7 test ACK");
    chk(test_sel == 5'd3 && test_active, "R7 test on", test_sel, 3);
    send(1'b1, 8'h60);
    expect_one(8'h00, "R7 test off ACK");
    chk(!test_active, "R7 test off", test_active, 0);
  endtask

  task automatic t_undef();
    send(1'b1, 8'h02);
    expect_one(8'h00, "R8 configure ACK");
    send(1'b1, 8'hC0);
    expect_none("R8 undefined silent");
    send(1'b0, 8'h99);
    expect_none("R8 pending kept");
    send(1'b1, 8'h42);
    expect_read(8'h99, "R8 configure completed");
  endtask

  task automatic t_stall();
    tx_ready = 1'b0;
    @(negedge clk);
    rx_valid = 1'b1; rx_ctrl = 1'b1; rx_byte = 8'h42;
    @(negedge clk);
    rx_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(tx_valid && tx_byte == 8'h01 && tx_ctrl, "R10 held", tx_byte, 8'h01);
      chk(!rx_ready, "R10 rx blocked", rx_ready, 0);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_byte == 8'h99 && !tx_ctrl, "R10 order", tx_byte, 8'h99);
    @(negedge clk);
    chk(!tx_valid && rx_ready, "R10 drained", {tx_valid, rx_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config_enquire();
    t_idle_data();
    t_cancel();
    t_sleep();
    t_xmit();
    t_test();
    t_undef();
    t_stall();
    finish_run();
  end
endmodule